// File: doc/BRIEF.md
# Byte-Addressed Two-Wire EEPROM Target

This block is a target on a two-wire serial bus (I2C/SMBus). It holds a 256-byte storage array and answers at a 7-bit bus address made of a base address (0x50 by default) plus a 3-bit instance select, so up to eight copies can share one bus. It watches the SCL and SDA lines, finds start, repeated start and stop conditions, and compares the address byte with its own. It pulls SDA low to acknowledge.

An 8-bit pointer selects the storage location. In a write, the first data byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then steps forward. In a read, each byte sent comes from the pointer, and the pointer then steps forward. A common use is a write of one pointer byte, then a repeated start and a read. Reset copies a power-up image from a wide input into the array and sets the pointer to zero. A sticky flag reports that some data byte has moved in either direction since reset.

Top module: `smbus_eeprom_target`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits equal 0x50 + `dev_sel`. Bit 0 of that byte is the direction: 0 is write and 1 is read. When the address does not match, the target drives nothing and ignores the bytes that follow, up to the next start or stop.
- R2: In a write, the first data byte after the address is loaded into the pointer and is not stored.
- R3: Each later byte of the same write is stored at the pointer. The pointer then increments and wraps from 255 to 0.
- R4: Each byte sent in a read is the content at the pointer, sent MSB first. The pointer then increments and wraps from 255 to 0.
- R5: A read goes on while the controller acknowledges each byte. A NACK ends it, and the next read starts at the location after the last byte sent.
- R6: While `rst_n` is low at a clock edge, the whole array is reloaded from `init_image`, with byte i taken from bits [8i+7:8i]. The pointer and the `accessed` flag are cleared.
- R7: `accessed` goes to 1 when a data byte is written or read, and it stays at 1 until reset. An address byte alone does not set it.
- R8: SDA is open drain. The target pulls it low to acknowledge a matching address and every written byte, and to send data zeros. It changes its pull only while SCL is low, and it releases the line when idle.
- R9: A stop or start that arrives in the middle of a byte aborts that byte. A partly received byte is never stored and never moves the pointer.
- R10: After a repeated start, the target decodes a new address byte. A pointer set in the write phase is used by the read phase that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. It must run at least 8 times faster than SCL. |
| rst_n | input | 1 | Synchronous active-low reset. |
| dev_sel | input | 3 | Instance select, added to the base address. |
| init_image | input | 2048 | Power-up image. Byte i sits in bits [8i+7:8i]. |
| scl_in | input | 1 | Bus clock line as seen at the pin. |
| sda_in | input | 1 | Bus data line as seen at the pin (the wired-AND value). |
| sda_pull_low | output | 1 | 1 pulls SDA low. 0 releases it. |
| accessed | output | 1 | Sticky flag set by any data byte transfer. |

## Verification
The assertions assume a well-formed bus. SCL is slow enough that each level lasts several system clocks after synchronization. The controller never makes a start or stop while the target pulls SDA low. SDA changes only with SCL low, except for the start and stop conditions themselves. The bench controller holds each SCL half period for eight system clocks. It moves SDA two clocks after the SCL falling edge and releases SDA during every acknowledge or data slot that belongs to the target. A mid-byte stop is made only while the target is releasing the line.

// File: rtl/smbus_eep_pkg.sv
// Package: types shared by the two-wire EEPROM target.
// Assumes: bus bytes are always 8 bits wide.
package smbus_eep_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,      // not addressed; wait for a start
        ST_RX,        // shifting in an address or write byte
        ST_ACK_WAIT,  // byte complete, wait for SCL low to pull ACK
        ST_ACK_DRV,   // holding ACK low through the ninth clock
        ST_TX,        // shifting out a read byte
        ST_TX_ACK,    // sampling the controller's ACK/NACK
        ST_TX_NEXT    // ACK seen, wait for SCL low to load the next byte
    } link_state_t;
endpackage

// File: rtl/smbus_line_sync.sv
// Module: smbus_line_sync
// Brings SCL and SDA into the clk domain through a chain of SYNC_STAGES
// flops. It finds SCL edges and start/stop conditions.
// Assumes: clk is at least 8x faster than SCL and both lines idle high.
module smbus_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;

    // Shift both lines through the synchronizer and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_in};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_in};
        end
    end

    logic scl_prev;
    logic sda_prev;

    // Decode levels, edges and bus conditions from the synchronized lines.
    always_comb begin
        scl_lvl   = scl_pipe[SYNC_STAGES-1];
        sda_lvl   = sda_pipe[SYNC_STAGES-1];
        scl_prev  = scl_pipe[SYNC_STAGES];
        sda_prev  = sda_pipe[SYNC_STAGES];
        scl_rise  = scl_lvl && !scl_prev;
        scl_fall  = !scl_lvl && scl_prev;
        start_det = scl_lvl && scl_prev && sda_prev && !sda_lvl;
        stop_det  = scl_lvl && scl_prev && !sda_prev && sda_lvl;
    end
endmodule

// File: rtl/eep_store.sv
// Module: eep_store
// Byte array with one write port and one asynchronous read port.
// Reset copies the whole power-up image into the array.
// Assumes: init_image stays stable while reset is held.
module eep_store #(
    parameter int ADDR_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [(1<<ADDR_W)*smbus_eep_pkg::BYTE_W-1:0] init_image,
    input  logic                                   wr_en,
    input  logic [ADDR_W-1:0]                      wr_addr,
    input  logic [smbus_eep_pkg::BYTE_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]                      rd_addr,
    output logic [smbus_eep_pkg::BYTE_W-1:0]       rd_data
);
    import smbus_eep_pkg::*;
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    // Reload the image on reset, otherwise accept one byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= init_image[i*BYTE_W +: BYTE_W];
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Present the byte at the read pointer.
    always_comb rd_data = mem[rd_addr];

    // A write is visible at its location on the next cycle.
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/smbus_link.sv
// Module: smbus_link
// Byte-level protocol engine: address match, ACK generation, pointer
// handling, read shifting and the sticky access flag.
// Assumes: synchronized inputs from smbus_line_sync, and bytes of 8 bits.
module smbus_link #(
    parameter int         ADDR_W    = 8,
    parameter logic [6:0] BASE_ADDR = 7'h50
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [2:0]                        dev_sel,
    input  logic                              sda_lvl,
    input  logic                              scl_lvl,
    input  logic                              scl_rise,
    input  logic                              scl_fall,
    input  logic                              start_det,
    input  logic                              stop_det,
    input  logic [smbus_eep_pkg::BYTE_W-1:0]  rd_data,
    output logic                              wr_en,
    output logic [ADDR_W-1:0]                 wr_addr,
    output logic [smbus_eep_pkg::BYTE_W-1:0]  wr_data,
    output logic [ADDR_W-1:0]                 rd_addr,
    output logic                              sda_low,
    output logic                              accessed
);
    import smbus_eep_pkg::*;
    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);
    localparam logic [2:0]        LAST_BIT = 3'd7;

    link_state_t       state;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [ADDR_W-1:0] ptr;
    logic              is_addr;
    logic              first_data;
    logic              rw_read;

    logic [BYTE_W-1:0] rx_byte;
    logic [6:0]        my_addr;
    logic              byte_done;
    logic              ptr_load;

    // Assemble the byte being received and qualify byte completion.
    always_comb begin
        rx_byte   = {rx_sh, sda_lvl};
        my_addr   = BASE_ADDR + {4'b0000, dev_sel};
        byte_done = (state == ST_RX) && scl_rise && (bit_cnt == LAST_BIT);
        ptr_load  = byte_done && !is_addr && first_data;
        wr_en     = byte_done && !is_addr && !first_data;
        wr_addr   = ptr;
        wr_data   = rx_byte;
        rd_addr   = ptr;
    end

    // Protocol state, pointer and SDA pull sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            ptr        <= '0;
            is_addr    <= 1'b0;
            first_data <= 1'b0;
            rw_read    <= 1'b0;
            sda_low    <= 1'b0;
            accessed   <= 1'b0;
        end else if (start_det) begin
            state      <= ST_RX;
            bit_cnt    <= '0;
            is_addr    <= 1'b1;
            first_data <= 1'b1;
            sda_low    <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            sda_low <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        rx_sh   <= rx_byte[BYTE_W-2:0];
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == LAST_BIT) begin
                            if (is_addr) begin
                                is_addr <= 1'b0;
                                rw_read <= rx_byte[0];
                                state   <= (rx_byte[7:1] == my_addr) ? ST_ACK_WAIT : ST_IDLE;
                            end else begin
                                accessed <= 1'b1;
                                state    <= ST_ACK_WAIT;
                                if (first_data) begin
                                    ptr        <= ADDR_W'(rx_byte);
                                    first_data <= 1'b0;
                                end else begin
                                    ptr <= ptr + PTR_ONE;
                                end
                            end
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (scl_fall) begin
                        sda_low <= 1'b1;
                        state   <= ST_ACK_DRV;
                    end
                end
                ST_ACK_DRV, ST_TX_NEXT: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_read) begin
                            tx_sh    <= {rd_data[BYTE_W-2:0], 1'b0};
                            sda_low  <= !rd_data[BYTE_W-1];
                            ptr      <= ptr + PTR_ONE;
                            accessed <= 1'b1;
                            state    <= ST_TX;
                        end else begin
                            sda_low <= 1'b0;
                            state   <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            sda_low <= 1'b0;
                            state   <= ST_TX_ACK;
                        end else begin
                            sda_low <= !tx_sh[BYTE_W-1];
                            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 3'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        state <= sda_lvl ? ST_IDLE : ST_TX_NEXT;
                    end
                end
                default: ;
            endcase
        end
    end

    // The pull on SDA moves only while SCL is low.
    assert_sda_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !scl_lvl);

    // Once set, the access flag holds until reset.
    assert_accessed_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(accessed)) |-> accessed);

    // The pointer moves only by one step or by a load from a complete byte.
    assert_ptr_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (ptr != $past(ptr))) |-> ((ptr == $past(ptr) + PTR_ONE) || $past(ptr_load)));

    // A target that is not addressed never holds the line.
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_low);
endmodule

// File: rtl/smbus_eeprom_target.sv
// Module: smbus_eeprom_target
// Top of the two-wire EEPROM target: line synchronizer, protocol engine
// and byte store.
// Assumes: an external open-drain pad turns sda_pull_low into a low on
// SDA, and sda_in returns the wired-AND line value.
module smbus_eeprom_target #(
    parameter int         ADDR_W      = 8,
    parameter logic [6:0] BASE_ADDR   = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic [2:0]                                     dev_sel,
    input  logic [(1<<ADDR_W)*smbus_eep_pkg::BYTE_W-1:0]   init_image,
    input  logic                                           scl_in,
    input  logic                                           sda_in,
    output logic                                           sda_pull_low,
    output logic                                           accessed
);
    import smbus_eep_pkg::*;

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    smbus_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    smbus_link #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_link (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .sda_lvl(sda_lvl),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .sda_low(sda_pull_low), .accessed(accessed)
    );

    eep_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .init_image(init_image), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );
endmodule

// File: tb/smbus_eeprom_target_test.sv
module smbus_eeprom_target_test;
    localparam int H = 8;
    localparam logic [6:0] MY_ADDR = 7'h53;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] dev_sel = 3'd3;
    logic [2047:0] init_image;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_low;
    logic accessed;
    wire  bus_sda = sda_m & ~sda_pull_low;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [256];
    int  mptr = 0;
    bit  macc = 1'b0;
    bit  idle_cmp = 1'b0;

    always #2 clk = ~clk;

    smbus_eeprom_target uut (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .init_image(init_image),
        .scl_in(scl_m), .sda_in(bus_sda), .sda_pull_low(sda_pull_low),
        .accessed(accessed)
    );

    // Per-clock comparison against the model while the bus is idle.
    always @(negedge clk) begin
        if (idle_cmp && rst_n) begin
            checks++;
            if (accessed !== macc || sda_pull_low !== 1'b0) begin
                errors++;
                $display("FAIL R7/R8 idle: accessed=%0b pull=%0b expected accessed=%0b pull=0",
                         accessed, sda_pull_low, macc);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic load_model();
        for (int i = 0; i < 256; i++) mdl[i] = init_image[i*8 +: 8];
        mptr = 0;
        macc = 1'b0;
    endtask

    task automatic bus_start();
        idle_cmp = 1'b0;
        sda_m = 1'b1; scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        tick(2); sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(2); sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
        tick(4);
        idle_cmp = 1'b1;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            tick(2); sda_m = b[i]; tick(H-2);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        tick(2); sda_m = 1'b1; tick(H-2);
        scl_m = 1'b1; tick(H/2);
        ack = bus_sda; tick(H/2);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit nack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H); scl_m = 1'b1; tick(H/2);
            b[i] = bus_sda; tick(H/2);
            scl_m = 1'b0;
        end
        tick(2); sda_m = nack; tick(H-2);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1; tick(H-2);
    endtask

    // Write: address, pointer byte, data bytes; model follows R2/R3.
    task automatic do_write(input logic [7:0] p, input logic [7:0] d [], input int n);
        logic a;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a); chk8("R1 addr ack", {7'b0, a}, 8'h00);
        send_byte(p, a); chk8("R8 ptr ack", {7'b0, a}, 8'h00);
        mptr = p; macc = 1'b1;
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], a); chk8("R8 data ack", {7'b0, a}, 8'h00);
            mdl[mptr] = d[k]; mptr = (mptr + 1) % 256;
        end
    endtask

    // Read n bytes, NACK on the last; model follows R4/R5.
    task automatic read_bytes(input int n, input string req);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k == n - 1);
            chk8(req, b, mdl[mptr]);
            mptr = (mptr + 1) % 256; macc = 1'b1;
        end
    endtask

    task automatic addr_read();
        logic a;
        send_byte({MY_ADDR, 1'b1}, a); chk8("R10 read addr ack", {7'b0, a}, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d [];
        for (int i = 0; i < 256; i++) init_image[i*8 +: 8] = 8'((i * 7 + 3) % 256);
        load_model();
        tick(4); rst_n = 1'b1; tick(4);
        chk8("R6 reset pull", {7'b0, sda_pull_low}, 8'h00);
        chk8("R7 reset flag", {7'b0, accessed}, 8'h00);
        idle_cmp = 1'b1;

        // R1: address only, then stop: no access flag.
        bus_start();
        send_byte({MY_ADDR, 1'b0}, a); chk8("R1 match ack", {7'b0, a}, 8'h00);
        bus_stop();

        // R2, R3: pointer load then two stores.
        d = new[2]; d[0] = 8'hA1; d[1] = 8'hB2;
        do_write(8'h20, d, 2);
        bus_stop();

        // R10, R4: set pointer, repeated start, read across written bytes.
        d = new[0];
        do_write(8'h1F, d, 0);
        bus_rstart(); addr_read();
        read_bytes(4, "R4 read data");
        bus_stop();

        // R5: a fresh read continues after the last byte sent.
        bus_start(); addr_read(); read_bytes(1, "R5 resume after NACK"); bus_stop();

        // R1: another address is ignored, including its data bytes.
        bus_start();
        send_byte({7'h52, 1'b0}, a); chk8("R1 foreign addr nack", {7'b0, a}, 8'h01);
        send_byte(8'h00, a); chk8("R1 foreign data nack", {7'b0, a}, 8'h01);
        send_byte(8'h77, a); chk8("R1 foreign data2 nack", {7'b0, a}, 8'h01);
        bus_stop();
        bus_start(); addr_read(); read_bytes(1, "R1 pointer untouched"); bus_stop();

        // R3: writes wrap from 255 to 0, reads wrap too.
        d = new[3]; d[0] = 8'hC1; d[1] = 8'hC2; d[2] = 8'hC3;
        do_write(8'hFE, d, 3);
        bus_stop();
        d = new[0];
        do_write(8'hFE, d, 0);
        bus_rstart(); addr_read();
        read_bytes(4, "R3 wrap read");
        bus_stop();

        // R9: stop in the middle of a byte; nothing stored, pointer kept.
        do_write(8'h40, d, 0);
        send_bits(8'hFF, 4);
        bus_stop();
        bus_start(); addr_read(); read_bytes(1, "R9 partial byte dropped"); bus_stop();

        // R6: reset restores the image, pointer 0, flag cleared.
        idle_cmp = 1'b0;
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(2);
        load_model();
        tick(2); idle_cmp = 1'b1; tick(4);
        bus_start(); addr_read(); read_bytes(3, "R6 image after reset"); bus_stop();
        chk8("R7 flag after read", {7'b0, accessed}, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule